// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit decides where a 32-bit RISC core with 4-byte instructions fetches next. Each cycle it takes the current program counter, the 16-bit offset field and 26-bit target field of the instruction, the two source register values and a 4-bit control-transfer code. From these it forms the next fetch address. Control transfers that link also produce a write request for the return-address register.

The unit handles these cases:
- plain sequential flow;
- branches that compare two registers for equality or inequality;
- branches that test one register against zero, two of which also link;
- direct jumps with and without linking;
- jumps through a register.

The direct-jump target is built by concatenation inside the current 256 MB region, not by addition. All results are registered, so an input set presented before a rising clock edge appears on the outputs just after that edge.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `npc_o` equals the parameter `RESET_PC` (default 0x0000_1000), and `lnk_we_o`, `lnk_reg_o` and `lnk_val_o` are all zero.
- R2: Code 0 (sequential), and every unused code from 12 to 15, gives `npc_o` = `pc_i` + 4, wrapping modulo 2^32, with no link request.
- R3: A taken branch gives `npc_o` = `pc_i` + 4 + (sign-extended `boff_i` × 4), modulo 2^32. An offset of 25 therefore lands 104 bytes past `pc_i`.
- R4: Code 1 is taken when `rs_val_i` == `rt_val_i`. Code 2 is taken when they differ. When not taken, `npc_o` = `pc_i` + 4.
- R5: The zero tests read `rs_val_i` as two's complement, and a value counts as zero only when all 32 bits are 0. Code 3 is taken when the value is ≤ 0, code 4 when > 0, code 5 when < 0 and code 6 when ≥ 0.
- R6: Code 7 is taken when the value is < 0 and code 8 when it is ≥ 0. Both raise the link request whether taken or not, and when not taken they give `pc_i` + 4.
- R7: Code 9 gives `npc_o` = {`pc_i`[31:28], `jidx_i`, 2'b00}. With an upper nibble of 0, a field of 2500 reaches 10000.
- R8: Code 10 gives the same target as code 9 and raises the link request.
- R9: Code 11 gives `npc_o` = `rs_val_i` exactly, with no alignment applied.
- R10: `lnk_we_o` is 1 only for codes 7, 8 and 10. In that case `lnk_reg_o` = `LINK_REG` (default 31) and `lnk_val_o` = `pc_i` + 4. Otherwise both are 0.
- R11: Each output reflects the inputs sampled at the previous rising clock edge. No input affects an output within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Control-transfer code |
| pc_i | input | 32 | Address of the current instruction |
| boff_i | input | 16 | Branch offset field, in instructions |
| jidx_i | input | 26 | Direct-jump target field, in instructions |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| npc_o | output | 32 | Next fetch address |
| lnk_we_o | output | 1 | Return-address write request |
| lnk_reg_o | output | 5 | Register index for the return address |
| lnk_val_o | output | 32 | Return address to be written |

## Verification
The two functions that can fall in one cycle are the redirect of fetch and the return-address write. For codes 7, 8 and 10, both the target path and the link path are active in the same cycle and must not disturb each other. The random stimulus biases `rs_val_i` toward 0, -1, +1 and the two signed extremes, so the linking branches fall on both sides of their condition often. In every such cycle the bench judges `npc_o` against the computed target or fall-through address, and separately judges the link outputs against `pc_i` + 4 and index 31.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN    = 32;
    localparam int OFF_W   = 16;
    localparam int IDX_W   = 26;
    localparam int RIDX_W  = 5;
    localparam int ILEN_B  = 4;
    localparam int SHIFT   = $clog2(ILEN_B);
    localparam int PAGE_W  = XLEN - IDX_W - SHIFT;
    localparam int SEXT_W  = XLEN - OFF_W - SHIFT;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SEQ    = 4'd0,
        OP_BEQ    = 4'd1,
        OP_BNE    = 4'd2,
        OP_BLEZ   = 4'd3,
        OP_BGTZ   = 4'd4,
        OP_BLTZ   = 4'd5,
        OP_BGEZ   = 4'd6,
        OP_BLTZL  = 4'd7,
        OP_BGEZL  = 4'd8,
        OP_JMP    = 4'd9,
        OP_JMPL   = 4'd10,
        OP_JREG   = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        K_SEQ = 2'd0,
        K_BR  = 2'd1,
        K_JMP = 2'd2,
        K_JR  = 2'd3
    } kind_e;

    typedef struct packed {
        logic [XLEN-1:0]   npc;
        logic              lnk_we;
        logic [RIDX_W-1:0] lnk_reg;
        logic [XLEN-1:0]   lnk_val;
    } npc_state_t;

endpackage

// File: rtl/npc_op_decode.sv
module npc_op_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output kind_e           kind_o,
    output logic            link_o
);

    always_comb begin
        kind_o = K_SEQ;
        link_o = 1'b0;
        case (op_e'(op_i))
            OP_BEQ, OP_BNE, OP_BLEZ, OP_BGTZ, OP_BLTZ, OP_BGEZ: begin
                kind_o = K_BR;
            end
            OP_BLTZL, OP_BGEZL: begin
                kind_o = K_BR;
                link_o = 1'b1;
            end
            OP_JMP: begin
                kind_o = K_JMP;
            end
            OP_JMPL: begin
                kind_o = K_JMP;
                link_o = 1'b1;
            end
            OP_JREG: begin
                kind_o = K_JR;
            end
            default: begin
                kind_o = K_SEQ;
                link_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [XLEN-1:0] rs_i,
    input  logic [XLEN-1:0] rt_i,
    output logic            taken_o
);

    logic rs_zero;
    logic rs_neg;
    logic pair_eq;

    assign rs_zero = ~|rs_i;
    assign rs_neg  = rs_i[XLEN-1];
    assign pair_eq = (rs_i == rt_i);

    always_comb begin
        case (op_e'(op_i))
            OP_BEQ:             taken_o = pair_eq;
            OP_BNE:             taken_o = ~pair_eq;
            OP_BLEZ:            taken_o = rs_neg | rs_zero;
            OP_BGTZ:            taken_o = ~rs_neg & ~rs_zero;
            OP_BLTZ, OP_BLTZL:  taken_o = rs_neg;
            OP_BGEZ, OP_BGEZL:  taken_o = ~rs_neg;
            default:            taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] boff_i,
    input  logic [IDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  br_o,
    output logic [XLEN-1:0]  jmp_o
);

    logic [XLEN-1:0] off_bytes;

    assign seq_o     = pc_i + XLEN'(ILEN_B);
    assign off_bytes = {{SEXT_W{boff_i[OFF_W-1]}}, boff_i, {SHIFT{1'b0}}};
    assign br_o      = seq_o + off_bytes;
    assign jmp_o     = {pc_i[XLEN-1 -: PAGE_W], jidx_i, {SHIFT{1'b0}}};

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    parameter int          LINK_REG = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  op_i,
    input  logic [31:0] pc_i,
    input  logic [15:0] boff_i,
    input  logic [25:0] jidx_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] npc_o,
    output logic        lnk_we_o,
    output logic [4:0]  lnk_reg_o,
    output logic [31:0] lnk_val_o
);

    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    kind_e           kind;
    logic            link;
    logic            taken;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;

    npc_state_t st_d;
    npc_state_t st_q;

    npc_op_decode i_dec (
        .op_i   (op_i),
        .kind_o (kind),
        .link_o (link)
    );

    npc_cond_eval i_cond (
        .op_i    (op_i),
        .rs_i    (rs_val_i),
        .rt_i    (rt_val_i),
        .taken_o (taken)
    );

    npc_target_gen i_tgt (
        .pc_i   (pc_i),
        .boff_i (boff_i),
        .jidx_i (jidx_i),
        .seq_o  (seq_pc),
        .br_o   (br_pc),
        .jmp_o  (jmp_pc)
    );

    always_comb begin
        st_d = st_q;
        case (kind)
            K_BR:    st_d.npc = taken ? br_pc : seq_pc;
            K_JMP:   st_d.npc = jmp_pc;
            K_JR:    st_d.npc = rs_val_i;
            default: st_d.npc = seq_pc;
        endcase
        st_d.lnk_we  = link;
        st_d.lnk_reg = link ? LINK_IDX : '0;
        st_d.lnk_val = link ? seq_pc : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.npc     <= RESET_PC;
            st_q.lnk_we  <= 1'b0;
            st_q.lnk_reg <= '0;
            st_q.lnk_val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign npc_o     = st_q.npc;
    assign lnk_we_o  = st_q.lnk_we;
    assign lnk_reg_o = st_q.lnk_reg;
    assign lnk_val_o = st_q.lnk_val;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    parameter int          LINK_REG = 31
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_i,
    input logic [31:0] pc_i,
    input logic [15:0] boff_i,
    input logic [25:0] jidx_i,
    input logic [31:0] rs_val_i,
    input logic [31:0] rt_val_i,
    input logic [31:0] npc_o,
    input logic        lnk_we_o,
    input logic [4:0]  lnk_reg_o,
    input logic [31:0] lnk_val_o
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (npc_o == RESET_PC && !lnk_we_o && lnk_val_o == 32'd0));

    p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_i) == 4'd0 || $past(op_i) >= 4'd12))
        |-> (npc_o == $past(pc_i) + 32'd4 && !lnk_we_o));

    p_btgt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd1 && $past(rs_val_i) == $past(rt_val_i))
        |-> (npc_o == $past(pc_i) + 32'd4
                      + {{14{$past(boff_i[15])}}, $past(boff_i), 2'b00}));

    p_bfall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd1 && $past(rs_val_i) != $past(rt_val_i))
        |-> (npc_o == $past(pc_i) + 32'd4));

    p_jtgt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_i) == 4'd9 || $past(op_i) == 4'd10))
        |-> (npc_o == {$past(pc_i[31:28]), $past(jidx_i), 2'b00}));

    p_jreg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd11) |-> (npc_o == $past(rs_val_i)));

    p_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_i) == 4'd7 || $past(op_i) == 4'd8 || $past(op_i) == 4'd10))
        |-> (lnk_we_o && lnk_reg_o == 5'(LINK_REG) && lnk_val_o == $past(pc_i) + 32'd4));

    p_nolink_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && lnk_we_o)
        |-> ($past(op_i) == 4'd7 || $past(op_i) == 4'd8 || $past(op_i) == 4'd10));

endmodule

bind npc_unit npc_unit_chk #(
    .RESET_PC (RESET_PC),
    .LINK_REG (LINK_REG)
) i_npc_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .pc_i      (pc_i),
    .boff_i    (boff_i),
    .jidx_i    (jidx_i),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .npc_o     (npc_o),
    .lnk_we_o  (lnk_we_o),
    .lnk_reg_o (lnk_reg_o),
    .lnk_val_o (lnk_val_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] pc = '0;
    logic [15:0] boff = '0;
    logic [25:0] jidx = '0;
    logic [31:0] rs = '0;
    logic [31:0] rt = '0;
    logic [31:0] npc;
    logic        lwe;
    logic [4:0]  lreg;
    logic [31:0] lval;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    npc_unit #(.RESET_PC(RST_PC), .LINK_REG(31)) i_npc_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op), .pc_i(pc), .boff_i(boff),
        .jidx_i(jidx), .rs_val_i(rs), .rt_val_i(rt), .npc_o(npc),
        .lnk_we_o(lwe), .lnk_reg_o(lreg), .lnk_val_o(lval)
    );

    function automatic bit m_taken(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        case (o)
            4'd1:       return a == b;
            4'd2:       return a != b;
            4'd3:       return $signed(a) <= 0;
            4'd4:       return $signed(a) > 0;
            4'd5, 4'd7: return $signed(a) < 0;
            4'd6, 4'd8: return $signed(a) >= 0;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] m_npc(input logic [3:0] o, input logic [31:0] p,
                                          input logic [15:0] f, input logic [25:0] j,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] fall;
        fall = p + 32'd4;
        if (o >= 4'd1 && o <= 4'd8)
            return m_taken(o, a, b) ? fall + (32'($signed(f)) * 32'd4) : fall;
        if (o == 4'd9 || o == 4'd10)
            return (p & 32'hF000_0000) | (32'(j) << 2);
        if (o == 4'd11)
            return a;
        return fall;
    endfunction

    function automatic bit m_link(input logic [3:0] o);
        return (o == 4'd7) || (o == 4'd8) || (o == 4'd10);
    endfunction

    function automatic string m_req(input logic [3:0] o);
        case (o)
            4'd1, 4'd2:                 return "R4";
            4'd3, 4'd4, 4'd5, 4'd6:     return "R5";
            4'd7, 4'd8:                 return "R6";
            4'd9:                       return "R7";
            4'd10:                      return "R8";
            4'd11:                      return "R9";
            default:                    return "R2";
        endcase
    endfunction

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one vector before an edge, then judge outputs just after it (R11 latency).
    task automatic apply(input logic [3:0] o, input logic [31:0] p, input logic [15:0] f,
                         input logic [25:0] j, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] e_np;
        bit          e_lk;
        @(negedge clk);
        op = o; pc = p; boff = f; jidx = j; rs = a; rt = b;
        e_np = m_npc(o, p, f, j, a, b);
        e_lk = m_link(o);
        @(posedge clk);
        #1;
        chk32(m_req(o), npc, e_np);
        chk32("R10", {lwe, 26'd0, lreg}, e_lk ? {1'b1, 26'd0, 5'd31} : 32'd0);
        chk32("R10", lval, e_lk ? p + 32'd4 : 32'd0);
    endtask

    function automatic logic [31:0] pick_reg();
        case ($urandom % 7)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h0000_0001;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        op = 4'd9; pc = 32'hFFFF_FFF0; jidx = 26'h3FF_FFFF; rs = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1;
        chk32("R1", npc, RST_PC);
        chk32("R1", {31'd0, lwe}, 32'd0);
        chk32("R1", lval, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: offset 25 lands 104 bytes on
        apply(4'd1, 32'h0000_0400, 16'd25, 26'd0, 32'd7, 32'd7);
        chk32("R3", npc, 32'h0000_0400 + 32'd104);
        // R3: negative offset below zero wraps
        apply(4'd2, 32'h0000_0008, 16'hFFF0, 26'd0, 32'd1, 32'd2);
        chk32("R3", npc, 32'h0000_000C - 32'd64);
        // R4: not-equal falls through when equal
        apply(4'd2, 32'h0000_2000, 16'd8, 26'd0, 32'd5, 32'd5);
        // R5: zero edge for each zero test
        apply(4'd3, 32'h100, 16'd4, 26'd0, 32'd0, 32'd0);
        apply(4'd4, 32'h100, 16'd4, 26'd0, 32'd0, 32'd0);
        apply(4'd5, 32'h100, 16'd4, 26'd0, 32'd0, 32'd0);
        apply(4'd6, 32'h100, 16'd4, 26'd0, 32'd0, 32'd0);
        apply(4'd4, 32'h100, 16'd4, 26'd0, 32'h8000_0000, 32'd0);
        // R6: linking branch, not taken yet linking
        apply(4'd7, 32'h0000_3000, 16'd3, 26'd0, 32'd0, 32'd0);
        apply(4'd8, 32'h0000_3000, 16'd3, 26'd0, 32'hFFFF_FFFF, 32'd0);
        // R7: field 2500 reaches 10000
        apply(4'd9, 32'h0000_0040, 16'd0, 26'd2500, 32'd0, 32'd0);
        chk32("R7", npc, 32'd10000);
        // R8: region bits preserved on linking jump
        apply(4'd10, 32'hA000_0010, 16'd0, 26'd2500, 32'd0, 32'd0);
        // R9: unaligned register target passes through
        apply(4'd11, 32'h0000_0500, 16'd0, 26'd0, 32'h0000_0123, 32'd0);
        // R2: wrap at top of address space and unused codes
        apply(4'd0, 32'hFFFF_FFFC, 16'hFFFF, 26'h3FF_FFFF, 32'd0, 32'd0);
        apply(4'd13, 32'h0000_7000, 16'd9, 26'd9, 32'hFFFF_FFFF, 32'd0);
        apply(4'd15, 32'h0000_7004, 16'd9, 26'd9, 32'd0, 32'd0);
        // R11: back-to-back vectors each seen exactly one edge later
        apply(4'd11, 32'h0, 16'd0, 26'd0, 32'hDEAD_BEE0, 32'd0);
        apply(4'd0, 32'hDEAD_BEE0, 16'd0, 26'd0, 32'd0, 32'd0);
        chk32("R11", npc, 32'hDEAD_BEE4);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = pick_reg();
            b = ($urandom % 2) ? a : pick_reg();
            apply(4'($urandom % 16), $urandom & 32'hFFFF_FFFC, 16'($urandom),
                  26'($urandom), a, b);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule